// File: doc/BRIEF.md
# Register-Pair Sequential Divider

This block performs unsigned division for a 16-bit processor datapath. The dividend is 32 bits wide and comes from two 16-bit registers: the first supplies the upper half and the second the lower half. The divisor is a separate 16-bit operand. A single-cycle start pulse loads all three operands.

Before any iteration begins, the block compares the upper dividend half with the divisor. If the quotient cannot fit in 16 bits, the block aborts on the next cycle and raises the overflow flag. In that case both result words keep the original register contents. Otherwise it runs a restoring shift-subtract loop that yields one quotient bit per cycle. When the loop ends, the quotient takes the place of the upper word and the remainder takes the place of the lower word. A one-cycle done strobe then tells the datapath to write both words back into the same register pair.

Top module: `regpair_div`

## Requirements
- R1: After reset, quot_o, rem_o, ovf_o, done_o and busy_o are all 0.
- R2: When hi_i < dvsr_i (unsigned), quot_o = {hi_i,lo_i} / dvsr_i and rem_o = {hi_i,lo_i} % dvsr_i when done_o is asserted, with ovf_o = 0 and rem_o < divisor.
- R3: Overflow is detected exactly when hi_i >= dvsr_i (unsigned). On an accepted start that overflows, done_o and ovf_o are 1 in the very next cycle, and busy_o stays 0.
- R4: On overflow, quot_o equals the loaded hi_i and rem_o equals the loaded lo_i.
- R5: A non-overflowing start raises busy_o on the next cycle. done_o is asserted exactly W (16) cycles after the start edge, for one cycle only, and busy_o and done_o are never 1 together.
- R6: A divisor of zero always takes the overflow path.
- R7: start_i is ignored while busy_o is 1. The running operation completes with its own operands and its own timing.
- R8: quot_o and rem_o change only in cycles where done_o is 1 and hold their value otherwise. ovf_o is updated on each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| hi_i | input | 16 | Upper dividend word (first register) |
| lo_i | input | 16 | Lower dividend word (second register) |
| dvsr_i | input | 16 | Divisor |
| quot_o | output | 16 | Quotient; written back to the first register |
| rem_o | output | 16 | Remainder; written back to the second register |
| ovf_o | output | 1 | Overflow flag of the last accepted operation |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Iteration loop in progress |

## Verification
Several properties are checked on every cycle: the one-cycle early exit on overflow with both words preserved, the forced overflow for a zero divisor, the single-cycle done pulse that never overlaps busy, the remainder staying below the latched divisor, the divisor staying frozen during a run, and the result words holding between strobes. Only the bench scenarios can show that the quotient and remainder values are correct, that done arrives exactly 16 cycles after a normal start, and that a start pulse in the middle of a run leaves both the result and the timing untouched. Those scenarios combine random operands with directed boundary cases: the upper word equal to the divisor, the largest legal dividends, and a divisor of zero.

// File: rtl/regpair_div_pkg.sv
package regpair_div_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} div_st_e;
endpackage

// File: rtl/regpair_div_ovf.sv
module regpair_div_ovf #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] dvsr_i,
  output logic         ovf_o
);
  // quotient fits in W bits only if the upper word is below the divisor
  assign ovf_o = (hi_i >= dvsr_i);
endmodule

// File: rtl/regpair_div_step.sv
module regpair_div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] q_o
);
  logic [W:0] sh;
  logic       ge;

  assign sh    = {acc_i, q_i[W-1]};
  assign ge    = (sh >= {1'b0, dvsr_i});
  // result < divisor, so W-bit wraparound subtraction is exact
  assign acc_o = ge ? (sh[W-1:0] - dvsr_i) : sh[W-1:0];
  assign q_o   = {q_i[W-2:0], ge};
endmodule

// File: rtl/regpair_div_cnt.sv
module regpair_div_cnt #(
  parameter int W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/regpair_div.sv
module regpair_div
  import regpair_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o,
  output logic         done_o,
  output logic         busy_o
);
  div_st_e     st_q;
  logic [W-1:0] acc_q, q_q, dvsr_q;
  logic [W-1:0] acc_nx, q_nx;
  logic         ovf_w, last_w, accept, run;

  assign run    = (st_q == ST_RUN);
  assign accept = start_i && !run;
  assign busy_o = run;

  regpair_div_ovf #(.W(W)) u_ovf (
    .hi_i(hi_i), .dvsr_i(dvsr_i), .ovf_o(ovf_w)
  );

  regpair_div_step #(.W(W)) u_step (
    .acc_i(acc_q), .q_i(q_q), .dvsr_i(dvsr_q), .acc_o(acc_nx), .q_o(q_nx)
  );

  regpair_div_cnt #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(run), .last_o(last_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      q_q    <= '0;
      dvsr_q <= '0;
      quot_o <= '0;
      rem_o  <= '0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        ovf_o <= ovf_w;
        if (ovf_w) begin
          // early exit: pair keeps its contents
          quot_o <= hi_i;
          rem_o  <= lo_i;
          done_o <= 1'b1;
        end else begin
          acc_q  <= hi_i;
          q_q    <= lo_i;
          dvsr_q <= dvsr_i;
          st_q   <= ST_RUN;
        end
      end else if (run) begin
        acc_q <= acc_nx;
        q_q   <= q_nx;
        if (last_w) begin
          quot_o <= q_nx;
          rem_o  <= acc_nx;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
      end
    end
  end

  a_r3_ovf_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && hi_i >= dvsr_i) |=> (done_o && ovf_o && !busy_o));
  a_r4_ovf_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && hi_i >= dvsr_i) |=> (quot_o == $past(hi_i) && rem_o == $past(lo_i)));
  a_r6_zero_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && dvsr_i == '0) |=> ovf_o);
  a_r5_no_ovf_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && hi_i < dvsr_i) |=> (busy_o && !done_o));
  a_r5_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
  a_r2_rem_lt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o) |-> (rem_o < dvsr_q));
  a_r7_dvsr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dvsr_q));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o)));
endmodule

// File: tb/regpair_div_tb.sv
module regpair_div_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] hi = '0, lo = '0, dv = '0;
  logic [W-1:0] quot, rem;
  logic         ovf, done, busy;
  int           n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  regpair_div #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hi_i(hi), .lo_i(lo),
    .dvsr_i(dv), .quot_o(quot), .rem_o(rem), .ovf_o(ovf), .done_o(done), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] h, l, d);
    logic [31:0] n = {h, l};
    return W'(n / {16'd0, d});
  endfunction

  function automatic logic [W-1:0] ref_r(input logic [W-1:0] h, l, d);
    logic [31:0] n = {h, l};
    return W'(n % {16'd0, d});
  endfunction

  // interfere: pulse start with other operands mid-run (R7)
  task automatic run_op(input logic [W-1:0] h, l, d, input bit interfere);
    logic       exp_ovf = (h >= d);
    int         lat = 0;
    logic [W-1:0] pq = quot, pr = rem;
    @(negedge clk);
    hi = h; lo = l; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!exp_ovf) chk("R5 busy after start", busy, 1);
    while (!done && lat < 40) begin
      if (interfere && lat == 4) begin
        hi = ~h; lo = ~l; dv = 16'h0003; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (lat == 2) begin
        chk("R8 quot hold", quot, pq);
        chk("R8 rem hold", rem, pr);
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (exp_ovf) begin
      chk("R3 ovf latency", lat, 0);
      chk("R3 ovf flag", ovf, 1);
      chk("R4 quot keeps hi", quot, h);
      chk("R4 rem keeps lo", rem, l);
    end else begin
      chk(interfere ? "R7 latency unchanged" : "R5 latency", lat, W);
      chk("R2 ovf clear", ovf, 0);
      chk(interfere ? "R7 quotient" : "R2 quotient", quot, ref_q(h, l, d));
      chk(interfere ? "R7 remainder" : "R2 remainder", rem, ref_r(h, l, d));
    end
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R5 idle after done", busy, 0);
  endtask

  initial begin
    logic [W-1:0] d, h, l;
    void'($urandom(32'd20240611));
    #1;
    chk("R1 quot reset", quot, 0);
    chk("R1 rem reset", rem, 0);
    chk("R1 ovf reset", ovf, 0);
    chk("R1 done reset", done, 0);
    chk("R1 busy reset", busy, 0);
    #22 rst_n = 1'b1;

    run_op(16'h0000, 16'h0007, 16'h0002, 0);
    run_op(16'hFFFE, 16'hFFFF, 16'hFFFF, 0);
    run_op(16'h0000, 16'h0000, 16'h0001, 0);
    run_op(16'h1234, 16'h5678, 16'h1234, 0);   // R3 boundary: equal
    run_op(16'h8000, 16'h0001, 16'h0005, 0);   // R3 greater
    run_op(16'h0000, 16'h0005, 16'h0000, 0);   // R6 zero divisor
    run_op(16'hABCD, 16'h0123, 16'h0000, 0);   // R6
    run_op(16'h0010, 16'h2345, 16'h00A0, 1);   // R7

    for (int i = 0; i < 60; i++) begin
      d = W'($urandom);
      l = W'($urandom);
      if (i % 5 == 4) h = d + W'($urandom % 16);       // overflow mix
      else if (d == 0) begin d = 16'h0001; h = 0; end
      else h = W'($urandom % d);
      run_op(h, l, d, (i % 7 == 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule